// File: doc/BRIEF.md
# Progressive GF(2^8) Gauss-Jordan decoder

The decoder recovers a set of source blocks from randomly coded combinations of them. Each arriving coded block carries one coefficient byte per source block and a data payload. A coded payload is the sum over GF(2^8) of each source block scaled by its coefficient. The decoder reduces each arrival against the rows it already holds as soon as it arrives, so most of the decoding work happens while blocks are still being received. The held coefficient matrix always stays in reduced row-echelon form. Every row operation is applied to the coefficient bytes and to the data bytes of a row together.

An arrival that reduces to an all-zero coefficient row is linearly dependent on what is already held. It is discarded, and the held state is left unchanged. Once as many independent rows are held as there are source blocks, the coefficient matrix is the identity and each data row equals one source block. The decoder then streams the source blocks out in index order. Row operations work on a fixed-width lane of bytes. A row longer than the lane is processed in several lane-sized chunks.

Top module: `gfd_decoder`

## Requirements
- R1: After reset the outputs are as follows: `in_ready` 1, `rank` 0, `done` 0, `dropped` 0 and `out_valid` 0.
- R2: An arrival is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the fold of that arrival ends. For an independent arrival, `in_ready` returns to 1 exactly 2·N·C+C+2 edges after the accepting edge. For a dependent arrival it returns after N·C+1 edges. Here C = ceil((N_SRC+K_BYTES)/LANE_BYTES) and N = N_SRC.
- R3: `rank` rises by exactly one, on the edge where an independent arrival finishes. It never changes in any other way.
- R4: A dependent arrival raises `dropped` for exactly one cycle, on the edge where its fold ends, and leaves `rank` unchanged. This includes an all-zero coefficient row, a duplicate row and any linear combination of earlier arrivals. It also leaves the eventually decoded output unaffected.
- R5: `done` is 1 exactly when `rank` equals N_SRC. While `done` is 1, `in_ready` is 0.
- R6: From the cycle `done` rises, `out_valid` is 1 and the outputs present source block 0, 1, …, N_SRC−1 in turn. Byte j of `out_data` (bits 8j+7:8j) is byte j of that source block. The output advances on each edge where `out_valid` and `out_ready` are both 1. After the last block, `out_valid` stays 0.
- R7: Arithmetic is over GF(2^8) with reduction polynomial x^8+x^4+x^3+x^2+1 (0x11D). Addition is XOR.
- R8: Coefficient byte j of `in_coef` (bits 8j+7:8j) weights source block j. Arrivals may come in any order of pivot columns. Decoded data is correct for any order of independent arrivals.
- R9: While `in_ready` is 0, the values of `in_valid`, `in_coef` and `in_data` have no effect on the decoder.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_index` and `out_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coded block present |
| in_ready | output | 1 | Decoder can take a coded block |
| in_coef | input | N_SRC*8 | Coefficient bytes, byte j weights source j |
| in_data | input | K_BYTES*8 | Coded payload bytes |
| out_valid | output | 1 | Decoded block present |
| out_ready | input | 1 | Consumer takes the decoded block |
| out_index | output | IDX_W | Index of the presented source block |
| out_data | output | K_BYTES*8 | Decoded source block bytes |
| rank | output | RANK_W | Number of independent rows held |
| dropped | output | 1 | One-cycle pulse for a discarded dependent arrival |
| done | output | 1 | All source blocks recovered |

## Verification
The busy window has a fixed length. `in_ready`, `rank` and `dropped` change exactly 2·N·C+C+2 edges after an independent arrival is accepted, and N·C+1 edges after a dependent one. With the default parameters these are 20 and 9 edges. `done` and `out_valid` rise in the same cycle as the final `rank` step, and the output index advances one edge after each accepted output beat. The bench's behavioural model counts these windows edge by edge and decides independence with its own elimination. All outputs are compared on the falling edge, half a period after the edge that updated them. Junk inputs are driven throughout every busy and done window to confirm they change nothing.

// File: rtl/gfd_pkg.sv
package gfd_pkg;

   // low byte of the field reduction polynomial x^8+x^4+x^3+x^2+1
   localparam logic [7:0] GF_POLY_LOW = 8'h1D;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ELIM,
      ST_PIVOT,
      ST_SCALE,
      ST_BACK,
      ST_INSERT,
      ST_OUT,
      ST_FIN
   } gfd_state_e;

   // carry-less shift-and-add product, reduced on each overflow
   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = '0;
      sh  = b;
      for (int i = 0; i < 8; i++) begin
         if (a[i]) acc = acc ^ sh;
         sh = sh[7] ? ((sh << 1) ^ GF_POLY_LOW) : (sh << 1);
      end
      return acc;
   endfunction

   // inverse as a^254 by square-and-multiply; maps 0 to 0
   function automatic logic [7:0] gf_inv(input logic [7:0] a);
      logic [7:0] r;
      logic [7:0] p;
      r = 8'h01;
      p = a;
      for (int i = 0; i < 8; i++) begin
         if (i != 0) r = gf_mul(r, p);
         p = gf_mul(p, p);
      end
      return r;
   endfunction

endpackage

// File: rtl/gfd_inv_rom.sv
module gfd_inv_rom
   import gfd_pkg::*;
(
   input  logic [7:0] addr_i,
   output logic [7:0] inv_o
);

   logic [7:0] rom [256];

   for (genvar g = 0; g < 256; g++) begin : g_ent
      assign rom[g] = gf_inv(8'(g));
   end

   assign inv_o = rom[addr_i];

   always_comb begin
      // R7
      inv_rom_chk: assert (addr_i == 8'h00 || gf_mul(addr_i, inv_o) == 8'h01);
   end

endmodule

// File: rtl/gfd_lane_mac.sv
module gfd_lane_mac
   import gfd_pkg::*;
#(
   parameter int LANE_BYTES = 16,
   localparam int LANE_W = LANE_BYTES * 8
) (
   input  logic [LANE_W-1:0] acc_i,
   input  logic [LANE_W-1:0] mult_i,
   input  logic [7:0]        factor_i,
   output logic [LANE_W-1:0] res_o
);

   if (LANE_BYTES < 1) begin : g_bad_lane
      $error("gfd_lane_mac: LANE_BYTES must be at least 1");
   end

   for (genvar g = 0; g < LANE_BYTES; g++) begin : g_byte
      assign res_o[g*8 +: 8] = acc_i[g*8 +: 8] ^ gf_mul(factor_i, mult_i[g*8 +: 8]);
   end

endmodule

// File: rtl/gfd_lead_find.sv
module gfd_lead_find #(
   parameter int N_SRC = 4,
   parameter int IDX_W = 2
) (
   input  logic [N_SRC*8-1:0] coef_i,
   output logic               found_o,
   output logic [IDX_W-1:0]   idx_o
);

   if ((1 << IDX_W) < N_SRC) begin : g_bad_idx
      $error("gfd_lead_find: IDX_W too narrow for N_SRC");
   end

   // lowest-index nonzero coefficient wins
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (coef_i[i*8 +: 8] != 8'h00) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/gfd_decoder.sv
module gfd_decoder
   import gfd_pkg::*;
#(
   parameter int N_SRC      = 4,
   parameter int K_BYTES    = 20,
   parameter int LANE_BYTES = 16,
   localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int RANK_W = $clog2(N_SRC + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [N_SRC*8-1:0]   in_coef,
   input  logic [K_BYTES*8-1:0] in_data,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [IDX_W-1:0]     out_index,
   output logic [K_BYTES*8-1:0] out_data,
   output logic [RANK_W-1:0]    rank,
   output logic                 dropped,
   output logic                 done
);

   localparam int ROW_B  = N_SRC + K_BYTES;
   localparam int NCH    = (ROW_B + LANE_BYTES - 1) / LANE_BYTES;
   localparam int PAD_B  = NCH * LANE_BYTES;
   localparam int PAD_W  = PAD_B * 8;
   localparam int LANE_W = LANE_BYTES * 8;
   localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;

   if (N_SRC < 1 || N_SRC > 8) begin : g_bad_n
      $error("gfd_decoder: N_SRC must be within 1..8");
   end
   if (K_BYTES < 1 || K_BYTES > 64) begin : g_bad_k
      $error("gfd_decoder: K_BYTES must be within 1..64");
   end
   if (LANE_BYTES < 1) begin : g_bad_lane
      $error("gfd_decoder: LANE_BYTES must be at least 1");
   end

   gfd_state_e        state_q;
   logic [PAD_W-1:0]  fresh_q;
   logic [PAD_W-1:0]  held_q [N_SRC];
   logic [IDX_W-1:0]  piv_q  [N_SRC];
   logic [RANK_W-1:0] rank_q;
   logic [IDX_W-1:0]  slot_q;
   logic [IDX_W-1:0]  oidx_q;
   logic [IDX_W-1:0]  pnew_q;
   logic [CH_W-1:0]   chunk_q;
   logic [7:0]        fac_q;
   logic [7:0]        inv_q;
   logic              drop_q;

   logic              slot_live;
   logic              last_chunk;
   logic              last_slot;
   logic [LANE_W-1:0] fresh_chunk;
   logic [LANE_W-1:0] held_chunk;
   logic [7:0]        elim_fac;
   logic [7:0]        back_fac;
   logic [7:0]        first_fac;
   logic [7:0]        fac_use;
   logic [LANE_W-1:0] mac_acc;
   logic [LANE_W-1:0] mac_mult;
   logic [LANE_W-1:0] mac_res;
   logic              lead_found;
   logic [IDX_W-1:0]  lead_idx;
   logic [7:0]        lead_byte;
   logic [7:0]        lead_inv;
   logic [RANK_W-1:0] ins_pos;
   logic [IDX_W-1:0]  ins_idx;

   // ---------------- stepping over slots and chunks ----------------
   assign slot_live   = int'(slot_q) < int'(rank_q);
   assign last_chunk  = (chunk_q == CH_W'(NCH - 1));
   assign last_slot   = (slot_q == IDX_W'(N_SRC - 1));
   assign fresh_chunk = fresh_q[int'(chunk_q)*LANE_W +: LANE_W];
   assign held_chunk  = held_q[slot_q][int'(chunk_q)*LANE_W +: LANE_W];

   // forward step: new row's entry in the held row's pivot column
   assign elim_fac = slot_live ? fresh_q[int'(piv_q[slot_q])*8 +: 8] : 8'h00;
   // back step: held row's entry in the new pivot column
   assign back_fac = slot_live ? held_q[slot_q][int'(pnew_q)*8 +: 8] : 8'h00;

   always_comb begin
      case (state_q)
         ST_ELIM: first_fac = elim_fac;
         ST_BACK: first_fac = back_fac;
         default: first_fac = 8'h00;
      endcase
   end

   // the factor is read before chunk 0 is rewritten and held for later chunks
   assign fac_use  = (state_q == ST_SCALE) ? inv_q :
                     ((chunk_q == '0) ? first_fac : fac_q);
   assign mac_acc  = (state_q == ST_BACK)  ? held_chunk :
                     ((state_q == ST_SCALE) ? '0 : fresh_chunk);
   assign mac_mult = (state_q == ST_ELIM)  ? held_chunk : fresh_chunk;

   gfd_lane_mac #(.LANE_BYTES(LANE_BYTES)) u_mac (
      .acc_i    (mac_acc),
      .mult_i   (mac_mult),
      .factor_i (fac_use),
      .res_o    (mac_res)
   );

   // ---------------- pivot search and inverse ----------------
   gfd_lead_find #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_lead (
      .coef_i  (fresh_q[N_SRC*8-1:0]),
      .found_o (lead_found),
      .idx_o   (lead_idx)
   );

   assign lead_byte = fresh_q[int'(lead_idx)*8 +: 8];

   gfd_inv_rom u_inv (
      .addr_i (lead_byte),
      .inv_o  (lead_inv)
   );

   // ---------------- sorted insertion point ----------------
   always_comb begin
      ins_pos = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (i < int'(rank_q) && piv_q[i] < pnew_q) ins_pos = ins_pos + RANK_W'(1);
      end
   end
   assign ins_idx = IDX_W'(ins_pos);

   // ---------------- control and storage ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fresh_q <= '0;
         rank_q  <= '0;
         slot_q  <= '0;
         oidx_q  <= '0;
         pnew_q  <= '0;
         chunk_q <= '0;
         fac_q   <= '0;
         inv_q   <= '0;
         drop_q  <= 1'b0;
         for (int i = 0; i < N_SRC; i++) begin
            held_q[i] <= '0;
            piv_q[i]  <= '0;
         end
      end else begin
         drop_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (in_valid && in_ready) begin
                  fresh_q <= PAD_W'({in_data, in_coef});
                  slot_q  <= '0;
                  chunk_q <= '0;
                  state_q <= ST_ELIM;
               end
            end
            ST_ELIM: begin
               fresh_q[int'(chunk_q)*LANE_W +: LANE_W] <= mac_res;
               if (chunk_q == '0) fac_q <= fac_use;
               if (last_chunk) begin
                  chunk_q <= '0;
                  slot_q  <= last_slot ? '0 : slot_q + IDX_W'(1);
                  if (last_slot) state_q <= ST_PIVOT;
               end else begin
                  chunk_q <= chunk_q + CH_W'(1);
               end
            end
            ST_PIVOT: begin
               if (!lead_found) begin
                  drop_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  pnew_q  <= lead_idx;
                  inv_q   <= lead_inv;
                  chunk_q <= '0;
                  state_q <= ST_SCALE;
               end
            end
            ST_SCALE: begin
               fresh_q[int'(chunk_q)*LANE_W +: LANE_W] <= mac_res;
               if (last_chunk) begin
                  chunk_q <= '0;
                  slot_q  <= '0;
                  state_q <= ST_BACK;
               end else begin
                  chunk_q <= chunk_q + CH_W'(1);
               end
            end
            ST_BACK: begin
               held_q[slot_q][int'(chunk_q)*LANE_W +: LANE_W] <= mac_res;
               if (chunk_q == '0) fac_q <= fac_use;
               if (last_chunk) begin
                  chunk_q <= '0;
                  slot_q  <= last_slot ? '0 : slot_q + IDX_W'(1);
                  if (last_slot) state_q <= ST_INSERT;
               end else begin
                  chunk_q <= chunk_q + CH_W'(1);
               end
            end
            ST_INSERT: begin
               for (int i = 1; i < N_SRC; i++) begin
                  if (i > int'(ins_pos) && i <= int'(rank_q)) begin
                     held_q[i] <= held_q[i-1];
                     piv_q[i]  <= piv_q[i-1];
                  end
               end
               held_q[ins_idx] <= fresh_q;
               piv_q[ins_idx]  <= pnew_q;
               rank_q          <= rank_q + RANK_W'(1);
               oidx_q          <= '0;
               state_q         <= (int'(rank_q) + 1 == N_SRC) ? ST_OUT : ST_IDLE;
            end
            ST_OUT: begin
               if (out_ready) begin
                  if (oidx_q == IDX_W'(N_SRC - 1)) state_q <= ST_FIN;
                  else oidx_q <= oidx_q + IDX_W'(1);
               end
            end
            default: state_q <= ST_FIN;
         endcase
      end
   end

   assign in_ready  = (state_q == ST_IDLE) && (int'(rank_q) < N_SRC);
   assign out_valid = (state_q == ST_OUT);
   assign out_index = oidx_q;
   assign out_data  = held_q[oidx_q][N_SRC*8 +: K_BYTES*8];
   assign rank      = rank_q;
   assign dropped   = drop_q;
   assign done      = (int'(rank_q) == N_SRC);

   // ---------------- assertions ----------------
   // R2
   busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R3
   rank_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rank_q != $past(rank_q)) |-> (rank_q == $past(rank_q) + RANK_W'(1)));

   // R4
   drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dropped |=> !dropped);

   // R4
   drop_keeps_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dropped |-> $stable(rank_q));

   // R5
   done_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !in_ready);

   // R6
   out_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> done);

   // R10
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_index) && $stable(out_data)));

endmodule

// File: tb/gfd_decoder_test.sv
module gfd_decoder_test;

   localparam int CLK_PERIOD = 10;
   localparam int N      = 4;
   localparam int K      = 20;
   localparam int LB     = 16;
   localparam int NCH    = (N + K + LB - 1) / LB;
   localparam int T_IND  = 2 * N * NCH + NCH + 2;
   localparam int T_DEP  = N * NCH + 1;
   localparam int QMAX   = 64;
   localparam int IW     = (N > 1) ? $clog2(N) : 1;
   localparam int RW     = $clog2(N + 1);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic           in_ready;
   logic [N*8-1:0] in_coef = '0;
   logic [K*8-1:0] in_data = '0;
   logic           out_valid;
   logic           out_ready = 1'b0;
   logic [IW-1:0]  out_index;
   logic [K*8-1:0] out_data;
   logic [RW-1:0]  rank;
   logic           dropped;
   logic           done;

   int checks = 0;
   int errors = 0;

   // model state
   int src    [N][K];
   int q_coef [QMAX][N];
   int q_data [QMAX][K];
   int qn, qh;
   int bas  [N][N];
   int bpiv [N];
   int bcount;
   int m_rank, m_cnt, m_dep, m_drop, m_oidx;
   int cv [N];

   always #(CLK_PERIOD/2) clk = ~clk;

   gfd_decoder #(.N_SRC(N), .K_BYTES(K), .LANE_BYTES(LB)) uut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_coef(in_coef), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_index(out_index), .out_data(out_data),
      .rank(rank), .dropped(dropped), .done(done)
   );

   // field product, multiplicand doubled each bit (R7 polynomial 0x11D)
   function automatic int bmul(int a, int b);
      int r = 0;
      for (int i = 0; i < 8; i++) begin
         if (((b >> i) & 1) != 0) r = r ^ a;
         a = a << 1;
         if ((a & 'h100) != 0) a = a ^ 'h11D;
      end
      return r;
   endfunction

   function automatic int binv(int a);
      for (int x = 1; x < 256; x++) if (bmul(a, x) == 1) return x;
      return 0;
   endfunction

   task automatic chk(input string tag, input logic [K*8-1:0] act, input logic [K*8-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic push_cv();
      for (int j = 0; j < N; j++) q_coef[qn][j] = cv[j];
      for (int b = 0; b < K; b++) begin
         int s = 0;
         for (int j = 0; j < N; j++) s = s ^ bmul(cv[j], src[j][b]);
         q_data[qn][b] = s;
      end
      qn++;
   endtask

   task automatic push_random();
      for (int j = 0; j < N; j++) cv[j] = $urandom % 256;
      push_cv();
   endtask

   task automatic push_unit(input int u);
      for (int j = 0; j < N; j++) cv[j] = (j == u) ? 1 : 0;
      push_cv();
   endtask

   task automatic push_combo(input int a, input int fa, input int b, input int fb);
      for (int j = 0; j < N; j++) cv[j] = bmul(fa, q_coef[a][j]) ^ bmul(fb, q_coef[b][j]);
      push_cv();
   endtask

   // model's own elimination; returns 1 when the row adds nothing
   function automatic int absorb(input int idx);
      int v [N];
      int p, f, iv;
      for (int j = 0; j < N; j++) v[j] = q_coef[idx][j];
      for (int r = 0; r < bcount; r++) begin
         f = v[bpiv[r]];
         for (int j = 0; j < N; j++) v[j] = v[j] ^ bmul(f, bas[r][j]);
      end
      p = -1;
      for (int j = N - 1; j >= 0; j--) if (v[j] != 0) p = j;
      if (p < 0) return 1;
      iv = binv(v[p]);
      for (int j = 0; j < N; j++) bas[bcount][j] = bmul(iv, v[j]);
      bpiv[bcount] = p;
      bcount++;
      return 0;
   endfunction

   task automatic cycle(input bit always_take);
      logic [K*8-1:0] exp_data;
      bit m_ready, m_ov;
      @(negedge clk);
      m_ready = (m_cnt == 0) && (m_rank < N);
      m_ov    = (m_rank == N) && (m_oidx < N);
      chk("R2 in_ready", K*8'(in_ready), K*8'(m_ready));
      chk("R3 rank", K*8'(rank), K*8'(m_rank));
      chk("R4 dropped", K*8'(dropped), K*8'(m_drop));
      chk("R5 done", K*8'(done), K*8'(m_rank == N));
      chk("R6 out_valid", K*8'(out_valid), K*8'(m_ov));
      if (m_ov) begin
         for (int b = 0; b < K; b++) exp_data[b*8 +: 8] = 8'(src[m_oidx][b]);
         chk("R10 out_index", K*8'(out_index), K*8'(m_oidx));
         chk("R6 R7 R8 out_data", out_data, exp_data);
      end
      if (m_ready && qh < qn) begin
         in_valid = 1'b1;
         for (int j = 0; j < N; j++) in_coef[j*8 +: 8] = 8'(q_coef[qh][j]);
         for (int b = 0; b < K; b++) in_data[b*8 +: 8] = 8'(q_data[qh][b]);
      end else if (!m_ready) begin
         // R9: junk offered while the decoder is busy or done
         in_valid = 1'($urandom % 2);
         for (int j = 0; j < N; j++) in_coef[j*8 +: 8] = 8'($urandom);
         for (int b = 0; b < K; b++) in_data[b*8 +: 8] = 8'($urandom);
      end else begin
         in_valid = 1'b0;
      end
      out_ready = always_take ? 1'b1 : 1'($urandom % 2);
      @(posedge clk);
      m_drop = 0;
      if (m_cnt > 0) begin
         m_cnt--;
         if (m_cnt == 0) begin
            if (m_dep != 0) m_drop = 1;
            else m_rank++;
         end
      end else if (in_valid && m_ready) begin
         m_dep = absorb(qh);
         qh++;
         m_cnt = (m_dep != 0) ? T_DEP : T_IND;
      end
      if (m_ov && out_ready) m_oidx++;
   endtask

   task automatic reset_dut();
      in_valid  = 1'b0;
      out_ready = 1'b0;
      rst_n     = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 in_ready", K*8'(in_ready), K*8'(1));
      chk("R1 rank", K*8'(rank), '0);
      chk("R1 done", K*8'(done), '0);
      chk("R1 dropped", K*8'(dropped), '0);
      chk("R1 out_valid", K*8'(out_valid), '0);
      qn = 0; qh = 0; bcount = 0;
      m_rank = 0; m_cnt = 0; m_dep = 0; m_drop = 0; m_oidx = 0;
   endtask

   task automatic run_scn(input int kind);
      int guard;
      reset_dut();
      for (int j = 0; j < N; j++)
         for (int b = 0; b < K; b++) src[j][b] = $urandom % 256;
      case (kind)
         1: begin // R4: zero row, duplicate, combinations
            for (int j = 0; j < N; j++) cv[j] = 0;
            push_cv();
            push_random();
            push_combo(1, 1, 1, 0);
            push_random();
            push_combo(1, 7, 3, 200);
            push_combo(3, 1, 3, 0);
         end
         2: begin // R8: pivots arriving in reverse order, one repeat
            for (int u = N - 1; u >= 0; u--) begin
               push_unit(u);
               if (u == N - 2) push_unit(u);
            end
         end
         default: for (int i = 0; i < N; i++) push_random();
      endcase
      guard = 0;
      while (!(m_rank == N && m_oidx == N) && guard < 5000) begin
         if (qh == qn && m_cnt == 0 && m_rank < N) push_random();
         cycle(kind == 3);
         guard++;
      end
      repeat (4) cycle(1'b0);
   endtask

   initial begin
      for (int s = 0; s < 12; s++) run_scn(s % 4);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule